// File: doc/BRIEF.md
# Two-Level Preemptive Interrupt Arbiter

This block chooses which of NSRC interrupt sources is handed to the processor next. Each source presents a pending flag, an enable and a one-bit level (0 = low, 1 = high). The block samples these inputs once per clock. It then picks a winner: any high request beats every low request, and within one level the lowest index wins. It issues a one-cycle vector request together with the winning index. At the same time it returns a one-cycle clear pulse to the granted source, so that an edge-captured pending flag can drop by itself.

The block keeps one in-service bit per level. It uses these bits to decide whether a new request may preempt the routine that is running. A high request may interrupt a low routine. A high routine cannot be interrupted. A request whose level is equal to or below the running routine waits. The processor signals instruction boundaries with a strobe, and vectors are issued only on that strobe. It also signals a return from a service routine with a pulse. After such a return, one further instruction must complete before any new vector is issued.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, vec_req_o is 0, clr_o is all zeros, both in-service levels are clear and every sampled level bit is low.
- R2: Inputs are registered before they are decoded. A request that is present at one rising edge and still present at the next, with ibound_i and glb_en_i high during the cycle between, gives vec_req_o = 1 after that second edge.
- R3: A vector is issued only from a cycle in which ibound_i = 1 and glb_en_i = 1.
- R4: A source whose src_en_i bit is 0 never wins arbitration, even when its pending bit is 1.
- R5: When both levels have requests, the winner is the high request (hi_sel_i bit = 1) regardless of index.
- R6: Among requests of the same level, the one with the lowest index wins.
- R7: clr_o is high for exactly the cycle in which vec_req_o is high, with only bit vec_idx_o set. At all other times it is zero.
- R8: Issuing a vector marks its level as in service. A high request is issued while only a low routine is in service.
- R9: While a high routine is in service, no vector is issued. While only a low routine is in service, low requests are not issued.
- R10: A reti_i pulse clears the high in-service bit if it is set, and otherwise clears the low one.
- R11: No vector is issued in the cycle of reti_i, nor at the first ibound_i strobe after it. Issuing may resume from the strobe after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | NSRC | Pending flag per source |
| src_en_i | input | NSRC | Enable per source |
| hi_sel_i | input | NSRC | Level per source, 1 = high |
| glb_en_i | input | 1 | Global interrupt enable |
| reti_i | input | 1 | Return-from-routine pulse |
| ibound_i | input | 1 | Instruction-boundary strobe |
| vec_req_o | output | 1 | One-cycle vector request |
| vec_idx_o | output | $clog2(NSRC) | Index of the granted source |
| clr_o | output | NSRC | One-cycle clear to the granted source |

## Verification
The bench builds the block with NSRC = 5. Because 5 is not a power of two, the 3-bit index carries unused codes. Source 4 sits at the top edge of the range, so the tests can show that a high source at the largest index still beats low sources at smaller indices, and that lowest-index ordering holds across the full range. Five sources are also enough to hold a low routine, a preempting high routine and further waiting requests of both levels at the same time. This brings nested preemption, the clear order on return and the one-instruction delay after a return all within reach of a single directed sequence.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_sample.sv
module irq_sample #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic [NSRC-1:0] hi_sel_i,
  output logic [NSRC-1:0] req_lo_q,
  output logic [NSRC-1:0] req_hi_q
);
  logic [NSRC-1:0] live;
  assign live = pend_i & src_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_lo_q <= '0;
      req_hi_q <= '0;
    end else begin
      req_lo_q <= live & ~hi_sel_i;
      req_hi_q <= live & hi_sel_i;
    end
  end
endmodule

// File: rtl/irq_first.sv
module irq_first #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned IW   = 3
) (
  input  logic [NSRC-1:0] vec_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign found_o = |vec_i;
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import prio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic grant_i,
  input  lvl_e grant_lvl_i,
  input  logic reti_i,
  input  logic ibound_i,
  output logic ins_lo_o,
  output logic ins_hi_o,
  output logic hold_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ins_lo_o <= 1'b0;
      ins_hi_o <= 1'b0;
      hold_o   <= 1'b0;
    end else begin
      if (grant_i) begin
        if (grant_lvl_i == LVL_HI) ins_hi_o <= 1'b1;
        else                       ins_lo_o <= 1'b1;
      end else if (reti_i) begin
        if (ins_hi_o) ins_hi_o <= 1'b0;
        else          ins_lo_o <= 1'b0;
      end

      if (reti_i)        hold_o <= 1'b1;
      else if (ibound_i) hold_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  localparam int unsigned IW  = idx_width(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic [NSRC-1:0] hi_sel_i,
  input  logic            glb_en_i,
  input  logic            reti_i,
  input  logic            ibound_i,
  output logic            vec_req_o,
  output logic [IW-1:0]   vec_idx_o,
  output logic [NSRC-1:0] clr_o
);
  logic [NSRC-1:0] req_q [2];
  logic            found [2];
  logic [IW-1:0]   first [2];
  logic            ins_lo, ins_hi, hold;
  lvl_e            cand_lvl;
  logic [IW-1:0]   cand_idx;
  logic            cand_ok;
  logic            fire;

  irq_sample #(.NSRC(NSRC)) u_sample (
    .clk      (clk),
    .rst      (rst),
    .pend_i   (pend_i),
    .src_en_i (src_en_i),
    .hi_sel_i (hi_sel_i),
    .req_lo_q (req_q[0]),
    .req_hi_q (req_q[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    irq_first #(.NSRC(NSRC), .IW(IW)) u_first (
      .vec_i   (req_q[g]),
      .found_o (found[g]),
      .idx_o   (first[g])
    );
  end

  always_comb begin
    cand_lvl = LVL_LO;
    cand_idx = first[0];
    cand_ok  = 1'b0;
    if (found[1]) begin
      cand_lvl = LVL_HI;
      cand_idx = first[1];
      cand_ok  = !ins_hi;
    end else if (found[0]) begin
      cand_ok  = !ins_hi && !ins_lo;
    end
  end

  assign fire = ibound_i && glb_en_i && !reti_i && !hold && cand_ok;

  irq_level_track u_track (
    .clk         (clk),
    .rst         (rst),
    .grant_i     (fire),
    .grant_lvl_i (cand_lvl),
    .reti_i      (reti_i),
    .ibound_i    (ibound_i),
    .ins_lo_o    (ins_lo),
    .ins_hi_o    (ins_hi),
    .hold_o      (hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_req_o <= 1'b0;
      vec_idx_o <= '0;
      clr_o     <= '0;
    end else begin
      vec_req_o <= fire;
      clr_o     <= fire ? (NSRC'(1) << cand_idx) : '0;
      if (fire) vec_idx_o <= cand_idx;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned IW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            glb_en_i,
  input logic            reti_i,
  input logic            ibound_i,
  input logic            vec_req_o,
  input logic [IW-1:0]   vec_idx_o,
  input logic [NSRC-1:0] clr_o,
  input logic            ins_lo,
  input logic            ins_hi
);
  p_issue_on_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> ($past(ibound_i) && $past(glb_en_i)));

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_o));

  p_clr_matches_r7: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> (clr_o == (NSRC'(1) << vec_idx_o)));

  p_clr_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !vec_req_o |-> (clr_o == '0));

  p_level_marked_r8: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> (ins_hi || ins_lo));

  p_high_not_preempted_r9: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> !$past(ins_hi));

  p_no_issue_on_return_r11: assert property (@(posedge clk) disable iff (rst)
    $past(reti_i) |-> !vec_req_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .glb_en_i  (glb_en_i),
  .reti_i    (reti_i),
  .ibound_i  (ibound_i),
  .vec_req_o (vec_req_o),
  .vec_idx_o (vec_idx_o),
  .clr_o     (clr_o),
  .ins_lo    (ins_lo),
  .ins_hi    (ins_hi)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int unsigned N  = 5;
  localparam int unsigned IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pend = '0, en = '0, hi = '0;
  logic          glb = 1'b0, reti = 1'b0, ib = 1'b0;
  logic          vreq;
  logic [IW-1:0] vidx;
  logic [N-1:0]  clr;

  int applied = 0;
  int bad     = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NSRC(N)) uut (
    .clk(clk), .rst(rst), .pend_i(pend), .src_en_i(en), .hi_sel_i(hi),
    .glb_en_i(glb), .reti_i(reti), .ibound_i(ib),
    .vec_req_o(vreq), .vec_idx_o(vidx), .clr_o(clr)
  );

  // {pend, enable, level, expect request, expect index}
  localparam logic [18:0] TBL [8] = '{
    {5'b00001, 5'b11111, 5'b00000, 1'b1, 3'd0},  // R2 single low
    {5'b10100, 5'b11111, 5'b00000, 1'b1, 3'd2},  // R6 lowest index
    {5'b10100, 5'b11111, 5'b10000, 1'b1, 3'd4},  // R5 high at top index
    {5'b11111, 5'b11111, 5'b01010, 1'b1, 3'd1},  // R5 R6 two highs
    {5'b01000, 5'b10111, 5'b00000, 1'b0, 3'd0},  // R4 masked only
    {5'b11000, 5'b10111, 5'b00000, 1'b1, 3'd4},  // R4 masked skipped
    {5'b00000, 5'b11111, 5'b11111, 1'b0, 3'd0},  // R2 nothing pending
    {5'b10110, 5'b11011, 5'b00100, 1'b1, 3'd1}   // R4 R5 masked high
  };

  task automatic check_req(input logic er, input logic [IW-1:0] ei, input string tag);
    applied++;
    if (vreq !== er || (er && vidx !== ei)) begin
      bad++;
      $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d", tag, vreq, vidx, er, ei);
    end
  endtask

  task automatic check_clr(input logic [N-1:0] e, input string tag);
    applied++;
    if (clr !== e) begin
      bad++;
      $display("FAIL %s: clr=%b expected %b", tag, clr, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pend = '0; ib = 1'b0; reti = 1'b0; glb = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic er, input logic [IW-1:0] ei, input string tag);
    ib = 1'b1;
    @(negedge clk);
    ib = 1'b0;
    check_req(er, ei, tag);
  endtask

  task automatic ret();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    check_req(1'b0, '0, "R11 return cycle");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check_req(1'b0, '0, "R1 reset req");
    check_clr('0, "R1 reset clr");

    // table walk: R2 R4 R5 R6
    for (int k = 0; k < 8; k++) begin
      do_reset();
      {pend, en, hi} = TBL[k][18:4];
      glb = 1'b1; ib = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check_req(TBL[k][3], TBL[k][2:0], $sformatf("table %0d", k));
      ib = 1'b0;
    end

    // R3 gating, then R7 clear pulse
    do_reset();
    en = '1; hi = '0; pend = 5'b00100;
    glb = 1'b0; ib = 1'b1;
    idle(3);
    check_req(1'b0, '0, "R3 global disabled");
    glb = 1'b1; ib = 1'b0;
    idle(3);
    check_req(1'b0, '0, "R3 no boundary");
    strobe(1'b1, 3'd2, "R3 boundary with enable");
    check_clr(5'b00100, "R7 clear pulse");
    idle(1);
    check_clr('0, "R7 clear ends");

    // R8 R9 R10 R11 nesting
    do_reset();
    en = '1; hi = 5'b10010; glb = 1'b1;
    pend = 5'b01000; idle(1);
    strobe(1'b1, 3'd3, "R8 low routine starts");
    pend = 5'b10000; idle(1);
    strobe(1'b1, 3'd4, "R8 high preempts low");
    pend = 5'b00001; idle(1);
    strobe(1'b0, '0, "R9 low blocked under high");
    pend = 5'b00011; idle(1);
    strobe(1'b0, '0, "R9 high blocked under high");
    ret();
    strobe(1'b0, '0, "R11 first strobe after return");
    strobe(1'b1, 3'd1, "R10 high cleared first");
    pend = 5'b00001; idle(1);
    ret();
    strobe(1'b0, '0, "R11 hold after second return");
    strobe(1'b0, '0, "R9 low waits under low");
    ret();
    strobe(1'b0, '0, "R11 hold after last return");
    strobe(1'b1, 3'd0, "R10 low cleared last");

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule